// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block gives a host a locked configuration space reached through two byte-wide I/O ports. One port takes a register number, the other carries that register's data. Out of reset the space is closed. Writes to the index port are fed to a key matcher, and only a fixed four-byte key written in exact order opens the space. While the space is closed, data-port writes are dropped and reads of either port return all ones. A write of the exit value to the exit register closes the space again.

Once the space is open, a device-select register picks one of several logical devices. Registers numbered below 0x30 are global. These are the device select and the read-only chip identity and revision. Registers at 0x30 and above are banked per logical device. Each implemented device has an enable bit and a 16-bit I/O base address. The enable bits, the base addresses and the selected device number are driven out to the logic that owns each device. A pair of access strobes, with the current register number and the write data, lets downstream logic follow every accepted data-port access.

Top module: `keyed_cfg_port`

## Requirements
- R1: The index port is I/O address 0x2E and the data port is 0x2F. A write to 0x2E while open sets the register number, and later data-port accesses reach that register. A read of 0x2E while open returns the register number. A read of any other address returns 0x00.
- R2: After reset the space is closed, the selected device (`cfg_ldev`) is 0, every enable bit is clear and every base address is 0.
- R3: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port while closed opens the space (`cfg_open` goes to 1 after the fourth write).
- R4: While closed, a byte that breaks the key sends the matcher back to its first step. If that byte is 0x87, it counts as the first key byte, so a fresh key started there still opens the space.
- R5: While closed, data-port writes change no register, and reads of the data port and the index port return 0xFF.
- R6: While open, writing 0x02 to the data port with register 0x02 selected closes the space. Any other value written to register 0x02 has no effect.
- R7: Register 0x07 holds the selected logical device number. It reads back as written and is driven on `cfg_ldev`.
- R8: Registers 0x20 and 0x21 return the high and low bytes of the 16-bit chip ID. Register 0x22 returns the 4-bit revision in bits 3:0, with bits 7:4 zero. Writes to these three registers have no effect.
- R9: For each implemented device (by default 0x07 in slot 0, 0x09 in slot 1 and 0x0A in slot 2), register 0x30 bit 0 is the enable bit and reads with bits 7:1 zero. Registers 0x60 and 0x61 are the high and low bytes of the base address. Each device keeps its own copy. Slot i is driven on `dev_active[i]` and on `dev_base[16i+15:16i]`.
- R10: When the selected device number is not implemented, banked registers read 0x00 and writes to them change no device.
- R11: `cfg_wr_stb` and `cfg_rd_stb` are high during a data-port write or read while open, with `cfg_idx` showing the current register number and `cfg_wdata` the write byte. They stay low while closed and for index-port accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed port (combinational) |
| cfg_open | output | 1 | Space is unlocked |
| cfg_ldev | output | 8 | Selected logical device number |
| cfg_idx | output | 8 | Current register number |
| cfg_wdata | output | 8 | Byte of the current data-port write |
| cfg_wr_stb | output | 1 | Accepted data-port write |
| cfg_rd_stb | output | 1 | Accepted data-port read |
| dev_active | output | NDEV | Enable bit of each implemented device |
| dev_base | output | 16*NDEV | Base address of each implemented device |

## Verification
Directed sequences target the key matcher: a key broken at its last byte, a key restarted by 0x87 partway through, and a clean key. Together they separate exact-order matching from matchers that hold their step or that ignore restarts. Banked writes go to two implemented devices and one unimplemented device, which shows whether storage is truly per device and whether unknown devices are shielded. Random traffic then mixes key bytes, exit commands, device selects and banked register writes. It is checked against a bench model, which exposes any state that leaks across lock, unlock and device changes.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam logic [15:0] IDX_PORT  = 16'h002E;
    localparam logic [15:0] DATA_PORT = 16'h002F;

    localparam int KEY_LEN = 4;
    localparam int KSW     = $clog2(KEY_LEN);

    localparam logic [7:0] REG_EXIT   = 8'h02;
    localparam logic [7:0] EXIT_VAL   = 8'h02;
    localparam logic [7:0] REG_LDEV   = 8'h07;
    localparam logic [7:0] REG_ID_HI  = 8'h20;
    localparam logic [7:0] REG_ID_LO  = 8'h21;
    localparam logic [7:0] REG_REV    = 8'h22;
    localparam logic [7:0] BANK_START = 8'h30;
    localparam logic [7:0] REG_ENABLE = 8'h30;
    localparam logic [7:0] REG_BASE_H = 8'h60;
    localparam logic [7:0] REG_BASE_L = 8'h61;

    typedef struct packed {
        logic        enable;
        logic [15:0] base;
    } dev_regs_t;

    typedef struct packed {
        logic       idx_wr;
        logic       data_wr;
        logic       data_rd;
        logic [7:0] wdata;
    } host_acc_t;

    function automatic logic [7:0] key_byte(input logic [KSW-1:0] step);
        case (step)
            2'd0:    return 8'h87;
            2'd1:    return 8'h01;
            default: return 8'h55;
        endcase
    endfunction

    function automatic logic is_banked(input logic [7:0] idx);
        return idx >= BANK_START;
    endfunction

endpackage

// File: rtl/cfgsp_key_match.sv
module cfgsp_key_match
    import cfgsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    input  logic       exit_req,
    output logic       unlocked
);
    localparam logic [KSW-1:0] LAST_STEP = KSW'(KEY_LEN - 1);

    logic [KSW-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
            step_q   <= '0;
        end else if (unlocked) begin
            step_q <= '0;
            if (exit_req) begin
                unlocked <= 1'b0;
            end
        end else if (idx_wr) begin
            if (wdata == key_byte(step_q)) begin
                if (step_q == LAST_STEP) begin
                    unlocked <= 1'b1;
                    step_q   <= '0;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end else if (wdata == key_byte('0)) begin
                step_q <= KSW'(1);
            end else begin
                step_q <= '0;
            end
        end
    end

endmodule

// File: rtl/cfgsp_global_regs.sv
module cfgsp_global_regs
    import cfgsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr_en,
    input  logic       data_wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] idx_q,
    output logic [7:0] ldev_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            ldev_q <= '0;
        end else begin
            if (idx_wr_en) begin
                idx_q <= wdata;
            end
            if (data_wr_en && idx_q == REG_LDEV) begin
                ldev_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/cfgsp_dev_bank.sv
module cfgsp_dev_bank
    import cfgsp_pkg::*;
#(
    parameter logic [7:0] DEV_NUM = 8'h07
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    input  logic [7:0] ldev,
    output dev_regs_t  regs,
    output logic       hit,
    output logic [7:0] rd_data
);
    assign hit = (ldev == DEV_NUM);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en && hit) begin
            case (idx)
                REG_ENABLE: regs.enable     <= wdata[0];
                REG_BASE_H: regs.base[15:8] <= wdata;
                REG_BASE_L: regs.base[7:0]  <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            REG_ENABLE: rd_data = {7'b0, regs.enable};
            REG_BASE_H: rd_data = regs.base[15:8];
            REG_BASE_L: rd_data = regs.base[7:0];
            default:    rd_data = 8'h00;
        endcase
        if (!hit) begin
            rd_data = 8'h00;
        end
    end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import cfgsp_pkg::*;
#(
    parameter int                  NDEV     = 3,
    parameter logic [NDEV*8-1:0]   DEV_NUMS = 24'h0A_09_07,
    parameter logic [15:0]         CHIP_ID  = 16'h8716,
    parameter logic [3:0]          CHIP_REV = 4'h2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        io_addr,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    output logic               cfg_open,
    output logic [7:0]         cfg_ldev,
    output logic [7:0]         cfg_idx,
    output logic [7:0]         cfg_wdata,
    output logic               cfg_wr_stb,
    output logic               cfg_rd_stb,
    output logic [NDEV-1:0]    dev_active,
    output logic [NDEV*16-1:0] dev_base
);
    host_acc_t  acc;
    logic       exit_req;
    logic [7:0] idx_q;
    logic [7:0] ldev_q;
    logic [7:0] glob_rd;
    logic [7:0] bank_or;
    logic [7:0] reg_rd;

    dev_regs_t  bank_regs [NDEV];
    logic [7:0] bank_rd   [NDEV];
    logic [NDEV-1:0] bank_hit;

    assign acc.idx_wr  = io_wr && (io_addr == IDX_PORT);
    assign acc.data_wr = io_wr && (io_addr == DATA_PORT) && cfg_open;
    assign acc.data_rd = io_rd && (io_addr == DATA_PORT) && cfg_open;
    assign acc.wdata   = io_wdata;

    assign exit_req = acc.data_wr && (idx_q == REG_EXIT) && (acc.wdata == EXIT_VAL);

    cfgsp_key_match u_key (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (acc.idx_wr),
        .wdata    (acc.wdata),
        .exit_req (exit_req),
        .unlocked (cfg_open)
    );

    cfgsp_global_regs u_glob (
        .clk        (clk),
        .rst        (rst),
        .idx_wr_en  (acc.idx_wr && cfg_open),
        .data_wr_en (acc.data_wr),
        .wdata      (acc.wdata),
        .idx_q      (idx_q),
        .ldev_q     (ldev_q)
    );

    for (genvar g = 0; g < NDEV; g++) begin : g_bank
        cfgsp_dev_bank #(
            .DEV_NUM (DEV_NUMS[8*g +: 8])
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (acc.data_wr && is_banked(idx_q)),
            .idx     (idx_q),
            .wdata   (acc.wdata),
            .ldev    (ldev_q),
            .regs    (bank_regs[g]),
            .hit     (bank_hit[g]),
            .rd_data (bank_rd[g])
        );
        assign dev_active[g]         = bank_regs[g].enable;
        assign dev_base[16*g +: 16]  = bank_regs[g].base;
    end

    always_comb begin
        bank_or = 8'h00;
        for (int i = 0; i < NDEV; i++) begin
            bank_or = bank_or | bank_rd[i];
        end
    end

    always_comb begin
        case (idx_q)
            REG_LDEV:  glob_rd = ldev_q;
            REG_ID_HI: glob_rd = CHIP_ID[15:8];
            REG_ID_LO: glob_rd = CHIP_ID[7:0];
            REG_REV:   glob_rd = {4'b0, CHIP_REV};
            default:   glob_rd = 8'h00;
        endcase
    end

    assign reg_rd = is_banked(idx_q) ? bank_or : glob_rd;

    always_comb begin
        if (io_addr == IDX_PORT) begin
            io_rdata = cfg_open ? idx_q : 8'hFF;
        end else if (io_addr == DATA_PORT) begin
            io_rdata = cfg_open ? reg_rd : 8'hFF;
        end else begin
            io_rdata = 8'h00;
        end
    end

    assign cfg_ldev   = ldev_q;
    assign cfg_idx    = idx_q;
    assign cfg_wdata  = acc.wdata;
    assign cfg_wr_stb = acc.data_wr;
    assign cfg_rd_stb = acc.data_rd;

endmodule

// File: rtl/cfgsp_checker.sv
module cfgsp_checker
    import cfgsp_pkg::*;
#(
    parameter int           NDEV    = 3,
    parameter logic [15:0]  CHIP_ID = 16'h8716
) (
    input logic               clk,
    input logic               rst,
    input logic [15:0]        io_addr,
    input logic               io_wr,
    input logic [7:0]         io_wdata,
    input logic [7:0]         io_rdata,
    input logic               cfg_open,
    input logic [7:0]         cfg_ldev,
    input logic               cfg_wr_stb,
    input logic               cfg_rd_stb,
    input logic [NDEV-1:0]    dev_active,
    input logic [NDEV*16-1:0] dev_base,
    input logic [7:0]         idx_q
);
    a_r3_open_follows_key_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(io_wr && io_addr == IDX_PORT && io_wdata == 8'h55));

    a_r5_closed_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && io_wr && io_addr == DATA_PORT)
        |=> ($stable(dev_active) && $stable(dev_base) && $stable(cfg_ldev)));

    a_r5_closed_read_ones: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && io_addr == DATA_PORT) |-> io_rdata == 8'hFF);

    a_r6_exit_closes: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && io_wr && io_addr == DATA_PORT && idx_q == REG_EXIT && io_wdata == EXIT_VAL)
        |=> !cfg_open);

    a_r7_ldev_holds: assert property (@(posedge clk) disable iff (rst)
        !(cfg_open && io_wr && io_addr == DATA_PORT && idx_q == REG_LDEV)
        |=> $stable(cfg_ldev));

    a_r8_id_high_read: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && io_addr == DATA_PORT && idx_q == REG_ID_HI) |-> io_rdata == CHIP_ID[15:8]);

    a_r11_no_strobe_closed: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |-> (!cfg_wr_stb && !cfg_rd_stb));

endmodule

bind keyed_cfg_port cfgsp_checker #(.NDEV(NDEV), .CHIP_ID(CHIP_ID)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .cfg_open   (cfg_open),
    .cfg_ldev   (cfg_ldev),
    .cfg_wr_stb (cfg_wr_stb),
    .cfg_rd_stb (cfg_rd_stb),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .idx_q      (idx_q)
);

// File: tb/keyed_cfg_port_bench.sv
module keyed_cfg_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] IDXP = 16'h002E;
    localparam logic [15:0] DATP = 16'h002F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_open;
    logic [7:0]  cfg_ldev, cfg_idx, cfg_wdata;
    logic        cfg_wr_stb, cfg_rd_stb;
    logic [2:0]  dev_active;
    logic [47:0] dev_base;

    keyed_cfg_port u_keyed_cfg_port (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
        .cfg_ldev(cfg_ldev), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_wr_stb(cfg_wr_stb), .cfg_rd_stb(cfg_rd_stb),
        .dev_active(dev_active), .dev_base(dev_base)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit         m_open = 0;
    int         m_step = 0;
    logic [7:0] m_idx = 0, m_ldev = 0;
    bit         m_en [3] = '{0, 0, 0};
    logic [15:0] m_base [3] = '{16'h0, 16'h0, 16'h0};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [7:0] d);
        case (d)
            8'h07:   return 0;
            8'h09:   return 1;
            8'h0A:   return 2;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] key_at(input int s);
        return (s == 0) ? 8'h87 : (s == 1) ? 8'h01 : 8'h55;
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        int s;
        if (a == IDXP) return m_open ? m_idx : 8'hFF;
        if (a != DATP) return 8'h00;
        if (!m_open) return 8'hFF;
        if (m_idx >= 8'h30) begin
            s = slot_of(m_ldev);
            if (s < 0) return 8'h00;
            case (m_idx)
                8'h30:   return {7'b0, m_en[s]};
                8'h60:   return m_base[s][15:8];
                8'h61:   return m_base[s][7:0];
                default: return 8'h00;
            endcase
        end
        case (m_idx)
            8'h07:   return m_ldev;
            8'h20:   return 8'h87;
            8'h21:   return 8'h16;
            8'h22:   return 8'h02;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
        int s;
        if (a == IDXP) begin
            if (m_open) m_idx = d;
            else if (d == key_at(m_step)) begin
                if (m_step == 3) begin m_open = 1; m_step = 0; end
                else m_step++;
            end else m_step = (d == 8'h87) ? 1 : 0;
        end else if (a == DATP && m_open) begin
            if (m_idx == 8'h02 && d == 8'h02) m_open = 0;
            else if (m_idx == 8'h07) m_ldev = d;
            else if (m_idx >= 8'h30) begin
                s = slot_of(m_ldev);
                if (s >= 0) begin
                    if (m_idx == 8'h30) m_en[s] = d[0];
                    if (m_idx == 8'h60) m_base[s][15:8] = d;
                    if (m_idx == 8'h61) m_base[s][7:0] = d;
                end
            end
        end
    endfunction

    task automatic check_state(input string req);
        logic [2:0] ea;
        logic [47:0] eb;
        for (int i = 0; i < 3; i++) begin
            ea[i] = m_en[i];
            eb[16*i +: 16] = m_base[i];
        end
        chk(cfg_open == m_open, {req, " open"}, cfg_open, m_open);
        chk(cfg_ldev == m_ldev, {req, " ldev"}, cfg_ldev, m_ldev);
        chk(dev_active == ea, {req, " enables"}, dev_active, ea);
        chk(dev_base == eb, {req, " bases"}, dev_base, eb);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bit es;
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1; io_rd = 0;
        #1;
        es = m_open && (a == DATP);
        chk(cfg_wr_stb == es, "R11 wr strobe", cfg_wr_stb, es);
        if (es) begin
            chk(cfg_idx == m_idx && cfg_wdata == d, "R11 strobe idx/data",
                {cfg_idx, cfg_wdata}, {m_idx, d});
        end
        @(posedge clk);
        #1 io_wr = 0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        bit es;
        logic [7:0] e;
        @(negedge clk);
        io_addr = a; io_rd = 1; io_wr = 0;
        #1;
        e = exp_read(a);
        chk(io_rdata == e, req, io_rdata, e);
        es = m_open && (a == DATP);
        chk(cfg_rd_stb == es, "R11 rd strobe", cfg_rd_stb, es);
        @(posedge clk);
        #1 io_rd = 0;
    endtask

    task automatic unlock();
        wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    endtask

    task automatic setreg(input logic [7:0] r, input logic [7:0] d);
        wr(IDXP, r); wr(DATP, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] pick [10];
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R2 reset state
        chk(cfg_open == 0, "R2 closed", cfg_open, 0);
        chk(cfg_ldev == 0, "R2 ldev", cfg_ldev, 0);
        chk(dev_active == 0, "R2 enables", dev_active, 0);
        chk(dev_base == 0, "R2 bases", dev_base, 0);
        // R5 closed: reads all ones, writes dropped
        rd(DATP, "R5 closed data read");
        rd(IDXP, "R5 closed index read");
        wr(DATP, 8'h09);
        check_state("R5 closed write");
        rd(16'h0060, "R1 other address");
        // R4 broken key then restart by 0x87
        wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h12);
        check_state("R4 broken key");
        wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h87);
        wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
        chk(cfg_open == 1, "R4 restart key opens", cfg_open, 1);
        check_state("R3 open");
        // R1 index readback; R8 identity
        wr(IDXP, 8'h20); rd(IDXP, "R1 index readback");
        rd(DATP, "R8 id high");
        wr(IDXP, 8'h21); rd(DATP, "R8 id low");
        wr(IDXP, 8'h22); rd(DATP, "R8 revision");
        wr(DATP, 8'hAA); rd(DATP, "R8 revision read-only");
        // R7 / R9 banked per device
        setreg(8'h07, 8'h07); rd(DATP, "R7 ldev readback");
        setreg(8'h30, 8'hFF); setreg(8'h60, 8'h02); setreg(8'h61, 8'h01);
        setreg(8'h07, 8'h09);
        setreg(8'h60, 8'h02); setreg(8'h61, 8'h08);
        wr(IDXP, 8'h30); rd(DATP, "R9 second device enable clear");
        check_state("R9 two devices");
        setreg(8'h07, 8'h07);
        wr(IDXP, 8'h30); rd(DATP, "R9 first device enable");
        wr(IDXP, 8'h61); rd(DATP, "R9 first device base low");
        // R10 unknown device
        setreg(8'h07, 8'h05);
        setreg(8'h30, 8'h01); rd(DATP, "R10 unknown enable");
        setreg(8'h60, 8'h77); rd(DATP, "R10 unknown base");
        check_state("R10 unknown device");
        // R6 exit
        setreg(8'h02, 8'h05);
        chk(cfg_open == 1, "R6 non-exit value", cfg_open, 1);
        wr(DATP, 8'h02);
        chk(cfg_open == 0, "R6 exit closes", cfg_open, 0);
        rd(DATP, "R5 read after exit");
        // random traffic
        pick = '{8'h87, 8'h01, 8'h55, 8'h02, 8'h07, 8'h30, 8'h60, 8'h61, 8'h20, 8'h22};
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0] b;
            op = $urandom_range(0, 9);
            b = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pick[$urandom_range(0, 9)];
            if (op < 5) wr(IDXP, b);
            else if (op < 8) begin
                if (m_idx == 8'h07) b = pick[$urandom_range(0, 9)] & 8'h0F;
                wr(DATP, b);
            end else if (op == 8) rd(DATP, "R9 random read");
            else rd(IDXP, "R1 random index read");
            if (n % 50 == 0) check_state("R9 random state");
        end
        check_state("R9 final state");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule